// File: doc/BRIEF.md
# Two-Phase Accumulator Processor

This block is a very small programmable processor. It has two data registers, a program counter, an instruction register, a condition register and a program store of fixed contents. Each instruction word is a bundle of datapath control fields. One field picks the ALU operation. One picks the second ALU operand from the register RB or from one of three constants. One bit picks which register receives the result, and a class field picks the sequential, jump or conditional-branch behaviour. The first ALU operand is always RA.

A two-state sequencer drives the machine. In the fetch cycle the word addressed by the program counter is latched into the instruction register. In the execute cycle the selected register, the condition flags and the program counter are updated. Every instruction therefore takes exactly two clock cycles. The only inputs are the clock and an active-low asynchronous reset. The registers, the flags, the program counter and the phase are brought out as debug outputs, so that the state can be observed after the built-in program has run.

Top module: `tcpu_core`

## Requirements
- R1: While reset is asserted, RA, RB, the program counter and all four flags read zero, and the phase output reads 0 (fetch).
- R2: The phase output alternates between 0 (fetch) and 1 (execute) on every clock, so each instruction occupies exactly two cycles.
- R3: The instruction register is loaded only at the end of a fetch cycle. RA, RB, the program counter and the flags change only at the end of an execute cycle.
- R4: Instruction bits [13:11] select the ALU operation, with operand A always RA: 000 add, 001 pass operand B, 010 AND, 011 OR, 100 XOR, 101 invert A, and 110/111 a result of zero.
- R5: Instruction bits [10:9] select operand B: 00 RB, 01 the constant 1, 10 the constant 0, 11 all ones (-1).
- R6: Instruction bit 8 selects the destination of an ALU result (0 RA, 1 RB). The other register keeps its value.
- R7: The flags output holds Z in bit 0 (result is zero), N in bit 1 (result MSB), C in bit 2 (carry out of an add) and V in bit 3 (two's-complement overflow of an add). C and V are zero after any other operation.
- R8: The flags are written only by ALU-class instructions (bits [15:14] = 00). Jumps and branches leave them unchanged.
- R9: Class 01 loads the program counter from bits [7:0]. ALU instructions and branches that are not taken load the program counter plus one, modulo 256.
- R10: Class 10 branches to bits [7:0] when the stored Z flag is set. Class 11 branches there when the stored N flag is set. The flags tested are those left by the most recent ALU instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_ra | output | 8 | Current value of register RA |
| dbg_rb | output | 8 | Current value of register RB |
| dbg_pc | output | 8 | Current program counter |
| dbg_flags | output | 4 | Condition register {V, C, N, Z} |
| dbg_phase | output | 1 | Sequencer phase: 0 fetch, 1 execute |

## Verification
The assertions take for granted that reset is low when the first clock edge arrives and that it is released well away from a rising edge. Their only stimulus is reset: once reset is released, the instruction stream comes wholly from the internal program store, so every ALU, jump and branch property is reached through that fixed program. The bench holds reset for several cycles and releases it shortly after a falling edge. It then only observes the machine while the program runs. The built-in program exercises every operation, every operand source, both destinations, a signed overflow, and branches both taken and not taken.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;

  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam int CLSW = 2;
  localparam int OPW  = 3;
  localparam int SRCW = 2;
  localparam int IW   = CLSW + OPW + SRCW + 1 + AW;
  localparam int FLW  = 4;

  typedef enum logic [CLSW-1:0] {
    CL_ALU = 2'b00,
    CL_JMP = 2'b01,
    CL_BZ  = 2'b10,
    CL_BN  = 2'b11
  } cls_e;

  typedef enum logic [OPW-1:0] {
    OP_ADD   = 3'b000,
    OP_PASSB = 3'b001,
    OP_AND   = 3'b010,
    OP_OR    = 3'b011,
    OP_XOR   = 3'b100,
    OP_NOT   = 3'b101,
    OP_RSV6  = 3'b110,
    OP_RSV7  = 3'b111
  } op_e;

  typedef enum logic [SRCW-1:0] {
    SRC_RB   = 2'b00,
    SRC_ONE  = 2'b01,
    SRC_ZERO = 2'b10,
    SRC_MONE = 2'b11
  } src_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;

  // MSB first: class, operation, operand-B source, destination, target
  typedef struct packed {
    cls_e            cls;
    op_e             op;
    src_e            src;
    logic            dst;
    logic [AW-1:0]   tgt;
  } instr_t;

  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } flags_t;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          c;
    logic          v;
  } alu_out_t;

  function automatic logic [DW-1:0] operand_b(src_e s, logic [DW-1:0] rb);
    case (s)
      SRC_RB:   return rb;
      SRC_ONE:  return DW'(1);
      SRC_ZERO: return '0;
      default:  return '1;
    endcase
  endfunction

  function automatic alu_out_t alu_eval(op_e op, logic [DW-1:0] a, logic [DW-1:0] b);
    alu_out_t    o;
    logic [DW:0] sum;
    o   = '0;
    sum = {1'b0, a} + {1'b0, b};
    case (op)
      OP_ADD: begin
        o.res = sum[DW-1:0];
        o.c   = sum[DW];
        o.v   = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
      end
      OP_PASSB: o.res = b;
      OP_AND:   o.res = a & b;
      OP_OR:    o.res = a | b;
      OP_XOR:   o.res = a ^ b;
      OP_NOT:   o.res = ~a;
      default:  o.res = '0;
    endcase
    return o;
  endfunction

  function automatic flags_t flags_of(alu_out_t o);
    flags_t f;
    f.z = (o.res == '0);
    f.n = o.res[DW-1];
    f.c = o.c;
    f.v = o.v;
    return f;
  endfunction

  function automatic instr_t mk(cls_e c, op_e op, src_e s, logic d, logic [AW-1:0] t);
    instr_t i;
    i.cls = c;
    i.op  = op;
    i.src = s;
    i.dst = d;
    i.tgt = t;
    return i;
  endfunction

endpackage

// File: rtl/tcpu_seq.sv
module tcpu_seq
  import tcpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase,
  output logic   fetch_en,
  output logic   exec_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_FETCH;
    else        phase <= (phase == PH_FETCH) ? PH_EXEC : PH_FETCH;
  end

  assign fetch_en = (phase == PH_FETCH);
  assign exec_en  = (phase == PH_EXEC);

endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu
  import tcpu_pkg::*;
(
  input  op_e           op,
  input  src_e          src,
  input  logic [DW-1:0] ra,
  input  logic [DW-1:0] rb,
  output logic [DW-1:0] result,
  output flags_t        nflags
);

  alu_out_t      o;
  logic [DW-1:0] b_val;

  always_comb begin
    b_val  = operand_b(src, rb);
    o      = alu_eval(op, ra, b_val);
    result = o.res;
    nflags = flags_of(o);
  end

endmodule

// File: rtl/tcpu_cond.sv
module tcpu_cond
  import tcpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  flags_t nflags,
  input  cls_e   cls,
  output flags_t flags_q,
  output logic   take
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags_q <= '0;
    else if (upd) flags_q <= nflags;
  end

  always_comb begin
    case (cls)
      CL_JMP:  take = 1'b1;
      CL_BZ:   take = flags_q.z;
      CL_BN:   take = flags_q.n;
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/tcpu_rom.sv
module tcpu_rom
  import tcpu_pkg::*;
(
  input  logic [AW-1:0] addr,
  output instr_t        word
);

  function automatic instr_t rom_word(logic [AW-1:0] a);
    case (int'(a))
      0:  return mk(CL_ALU, OP_PASSB, SRC_ONE,  1'b1, AW'(0));
      1:  return mk(CL_ALU, OP_PASSB, SRC_MONE, 1'b0, AW'(0));
      2:  return mk(CL_ALU, OP_ADD,   SRC_ONE,  1'b0, AW'(0));
      3:  return mk(CL_BZ,  OP_ADD,   SRC_RB,   1'b0, AW'(5));
      4:  return mk(CL_ALU, OP_PASSB, SRC_MONE, 1'b1, AW'(0));
      5:  return mk(CL_BN,  OP_ADD,   SRC_RB,   1'b0, AW'(4));
      6:  return mk(CL_ALU, OP_ADD,   SRC_RB,   1'b0, AW'(0));
      7:  return mk(CL_ALU, OP_ADD,   SRC_ONE,  1'b0, AW'(0));
      8:  return mk(CL_ALU, OP_ADD,   SRC_ONE,  1'b0, AW'(0));
      9:  return mk(CL_ALU, OP_ADD,   SRC_RB,   1'b1, AW'(0));
      10: return mk(CL_ALU, OP_ADD,   SRC_MONE, 1'b0, AW'(0));
      11: return mk(CL_BZ,  OP_ADD,   SRC_RB,   1'b0, AW'(13));
      12: return mk(CL_JMP, OP_ADD,   SRC_RB,   1'b0, AW'(10));
      13: return mk(CL_ALU, OP_PASSB, SRC_ONE,  1'b0, AW'(0));
      14: return mk(CL_ALU, OP_ADD,   SRC_ZERO, 1'b1, AW'(0));
      15: return mk(CL_ALU, OP_ADD,   SRC_RB,   1'b0, AW'(0));
      16: return mk(CL_BN,  OP_ADD,   SRC_RB,   1'b0, AW'(18));
      17: return mk(CL_JMP, OP_ADD,   SRC_RB,   1'b0, AW'(14));
      18: return mk(CL_ALU, OP_OR,    SRC_RB,   1'b1, AW'(0));
      19: return mk(CL_ALU, OP_AND,   SRC_RB,   1'b0, AW'(0));
      20: return mk(CL_ALU, OP_XOR,   SRC_RB,   1'b0, AW'(0));
      21: return mk(CL_ALU, OP_NOT,   SRC_ZERO, 1'b1, AW'(0));
      22: return mk(CL_ALU, OP_RSV6,  SRC_RB,   1'b0, AW'(0));
      23: return mk(CL_ALU, OP_ADD,   SRC_MONE, 1'b1, AW'(0));
      // unused locations park the machine on a jump to themselves
      default: return mk(CL_JMP, OP_ADD, SRC_RB, 1'b0, a);
    endcase
  endfunction

  assign word = rom_word(addr);

endmodule

// File: rtl/tcpu_core.sv
module tcpu_core
  import tcpu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  output logic [DW-1:0]  dbg_ra,
  output logic [DW-1:0]  dbg_rb,
  output logic [AW-1:0]  dbg_pc,
  output logic [FLW-1:0] dbg_flags,
  output logic           dbg_phase
);

  phase_e        phase;
  logic          fetch_en;
  logic          exec_en;
  logic [DW-1:0] ra_q;
  logic [DW-1:0] rb_q;
  logic [AW-1:0] pc_q;
  instr_t        ir_q;
  instr_t        rom_q;
  logic [DW-1:0] alu_res;
  flags_t        alu_flags;
  flags_t        flags_q;

  // named events used by the logic below and by the bound checker
  logic          is_alu;
  logic          take;
  logic          wr_ra;
  logic          wr_rb;
  logic          flag_upd;
  logic [AW-1:0] pc_next;
  logic [IW-1:0] ir_bits;

  tcpu_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .fetch_en (fetch_en),
    .exec_en  (exec_en)
  );

  tcpu_rom u_rom (
    .addr (pc_q),
    .word (rom_q)
  );

  tcpu_alu u_alu (
    .op     (ir_q.op),
    .src    (ir_q.src),
    .ra     (ra_q),
    .rb     (rb_q),
    .result (alu_res),
    .nflags (alu_flags)
  );

  tcpu_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (flag_upd),
    .nflags  (alu_flags),
    .cls     (ir_q.cls),
    .flags_q (flags_q),
    .take    (take)
  );

  assign is_alu   = (ir_q.cls == CL_ALU);
  assign wr_ra    = exec_en && is_alu && !ir_q.dst;
  assign wr_rb    = exec_en && is_alu &&  ir_q.dst;
  assign flag_upd = exec_en && is_alu;
  assign pc_next  = take ? ir_q.tgt : pc_q + AW'(1);
  assign ir_bits  = ir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q <= '0;
      rb_q <= '0;
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (fetch_en) ir_q <= rom_q;
      if (wr_ra)    ra_q <= alu_res;
      if (wr_rb)    rb_q <= alu_res;
      if (exec_en)  pc_q <= pc_next;
    end
  end

  assign dbg_ra    = ra_q;
  assign dbg_rb    = rb_q;
  assign dbg_pc    = pc_q;
  assign dbg_flags = flags_q;
  assign dbg_phase = phase;

endmodule

// File: rtl/tcpu_core_chk.sv
module tcpu_core_chk
  import tcpu_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           phase,
  input logic [DW-1:0]  ra,
  input logic [DW-1:0]  rb,
  input logic [AW-1:0]  pc,
  input logic [FLW-1:0] flags,
  input logic [IW-1:0]  ir_bits,
  input logic           is_alu,
  input logic           take
);

  logic          ir_dst;
  logic [AW-1:0] ir_tgt;
  logic [1:0]    ir_cls;
  assign ir_dst = ir_bits[AW];
  assign ir_tgt = ir_bits[AW-1:0];
  assign ir_cls = ir_bits[IW-1:IW-2];

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (ra == '0 && rb == '0 && pc == '0 && flags == '0 && phase == 1'b0));

  p_fetch_to_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 1'b0) |=> (phase == 1'b1));

  p_exec_to_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 1'b1) |=> (phase == 1'b0));

  p_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 1'b0) |=> (ra == $past(ra) && rb == $past(rb) &&
                         pc == $past(pc) && flags == $past(flags)));

  p_ir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 1'b1) |=> $stable(ir_bits));

  p_dst_ra_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 1'b1 && is_alu && !ir_dst) |=> $stable(rb));

  p_dst_rb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 1'b1 && is_alu && ir_dst) |=> $stable(ra));

  p_flags_ra_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 1'b1 && is_alu && !ir_dst) |=> (flags[0] == (ra == '0) && flags[1] == ra[DW-1]));

  p_flags_rb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 1'b1 && is_alu && ir_dst) |=> (flags[0] == (rb == '0) && flags[1] == rb[DW-1]));

  p_branch_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 1'b1 && !is_alu) |=> $stable(flags));

  p_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 1'b1 && ir_cls == 2'b01) |=> (pc == $past(ir_tgt)));

  p_seq_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 1'b1 && !take) |=> (pc == AW'($past(pc) + AW'(1))));

  p_bz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 1'b1 && ir_cls == 2'b10 && flags[0]) |=> (pc == $past(ir_tgt)));

  p_bn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 1'b1 && ir_cls == 2'b11 && flags[1]) |=> (pc == $past(ir_tgt)));

endmodule

bind tcpu_core tcpu_core_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .phase   (dbg_phase),
  .ra      (dbg_ra),
  .rb      (dbg_rb),
  .pc      (dbg_pc),
  .flags   (dbg_flags),
  .ir_bits (ir_bits),
  .is_alu  (is_alu),
  .take    (take)
);

// File: tb/test_tcpu_core.sv
module test_tcpu_core;

  localparam int N_STEPS = 60;
  localparam int WD_MAX  = 4000;

  logic       clk;
  logic       rst_n;
  logic [7:0] dbg_ra;
  logic [7:0] dbg_rb;
  logic [7:0] dbg_pc;
  logic [3:0] dbg_flags;
  logic       dbg_phase;

  tcpu_core i_tcpu_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_ra    (dbg_ra),
    .dbg_rb    (dbg_rb),
    .dbg_pc    (dbg_pc),
    .dbg_flags (dbg_flags),
    .dbg_phase (dbg_phase)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [1:0] cls;
    logic [7:0] pc;
    logic [7:0] ra;
    logic [7:0] rb;
    logic [3:0] fl;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   n_done   = 0;
  bit   mon_on   = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  // Program image restated from the encoding in the requirements
  function automatic int enc(int c, int op, int s, int d, int t);
    return c * 16384 + op * 2048 + s * 512 + d * 256 + t;
  endfunction

  function automatic int prog(int a);
    case (a)
      0:  return enc(0, 1, 1, 1, 0);
      1:  return enc(0, 1, 3, 0, 0);
      2:  return enc(0, 0, 1, 0, 0);
      3:  return enc(2, 0, 0, 0, 5);
      4:  return enc(0, 1, 3, 1, 0);
      5:  return enc(3, 0, 0, 0, 4);
      6:  return enc(0, 0, 0, 0, 0);
      7:  return enc(0, 0, 1, 0, 0);
      8:  return enc(0, 0, 1, 0, 0);
      9:  return enc(0, 0, 0, 1, 0);
      10: return enc(0, 0, 3, 0, 0);
      11: return enc(2, 0, 0, 0, 13);
      12: return enc(1, 0, 0, 0, 10);
      13: return enc(0, 1, 1, 0, 0);
      14: return enc(0, 0, 2, 1, 0);
      15: return enc(0, 0, 0, 0, 0);
      16: return enc(3, 0, 0, 0, 18);
      17: return enc(1, 0, 0, 0, 14);
      18: return enc(0, 3, 0, 1, 0);
      19: return enc(0, 2, 0, 0, 0);
      20: return enc(0, 4, 0, 0, 0);
      21: return enc(0, 5, 2, 1, 0);
      22: return enc(0, 6, 0, 0, 0);
      23: return enc(0, 0, 3, 1, 0);
      default: return enc(1, 0, 0, 0, a);
    endcase
  endfunction

  // Driver: steps an instruction-level model and queues the state after each instruction
  task automatic drive_expected(input int steps);
    int pc = 0, ra = 0, rb = 0, z = 0, n = 0, c = 0, v = 0;
    for (int k = 0; k < steps; k++) begin
      int w, cls, op, src, dst, tgt, a, b, r, sa, sb;
      exp_t e;
      w   = prog(pc);
      cls = (w / 16384) % 4;
      op  = (w / 2048) % 8;
      src = (w / 512) % 4;
      dst = (w / 256) % 2;
      tgt = w % 256;
      if (cls == 0) begin
        a = ra;
        case (src)
          0: b = rb;
          1: b = 1;
          2: b = 0;
          default: b = 255;
        endcase
        c = 0; v = 0;
        case (op)
          0: begin
            r  = a + b;
            c  = (r > 255) ? 1 : 0;
            r  = r % 256;
            sa = (a > 127) ? a - 256 : a;
            sb = (b > 127) ? b - 256 : b;
            v  = ((sa + sb) > 127 || (sa + sb) < -128) ? 1 : 0;
          end
          1: r = b;
          2: r = a & b;
          3: r = a | b;
          4: r = a ^ b;
          5: r = 255 - a;
          default: r = 0;
        endcase
        z = (r == 0) ? 1 : 0;
        n = (r >= 128) ? 1 : 0;
        if (dst == 1) rb = r; else ra = r;
        pc = (pc + 1) % 256;
      end else if (cls == 1) begin
        pc = tgt;
      end else if ((cls == 2 && z == 1) || (cls == 3 && n == 1)) begin
        pc = tgt;
      end else begin
        pc = (pc + 1) % 256;
      end
      e.cls = 2'(cls);
      e.pc  = 8'(pc);
      e.ra  = 8'(ra);
      e.rb  = 8'(rb);
      e.fl  = 4'(v * 8 + c * 4 + n * 2 + z);
      exp_q.push_back(e);
    end
  endtask

  // Monitor: samples on the falling edge, compares after each execute cycle
  logic       have_prev = 1'b0;
  logic       prev_phase;
  logic [7:0] snap_ra, snap_rb, snap_pc;
  logic [3:0] snap_fl;

  always @(negedge clk) begin
    if (mon_on) begin
      if (have_prev) begin
        check(dbg_phase != prev_phase, "R2", "phase alternation", dbg_phase, ~prev_phase);
        if (dbg_phase == 1'b1) begin
          check({dbg_ra, dbg_rb, dbg_pc, dbg_flags} == {snap_ra, snap_rb, snap_pc, snap_fl},
                "R3", "state held through fetch",
                {dbg_ra, dbg_rb, dbg_pc, dbg_flags}, {snap_ra, snap_rb, snap_pc, snap_fl});
        end else if (prev_phase == 1'b1 && exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.cls == 2'd0) begin
            check(dbg_ra == e.ra, "R4/R5/R6", "RA after ALU op", dbg_ra, e.ra);
            check(dbg_rb == e.rb, "R4/R5/R6", "RB after ALU op", dbg_rb, e.rb);
            check(dbg_flags == e.fl, "R7", "flags after ALU op", dbg_flags, e.fl);
            check(dbg_pc == e.pc, "R9", "sequential PC", dbg_pc, e.pc);
          end else begin
            check(dbg_ra == e.ra && dbg_rb == e.rb, "R8", "registers across branch",
                  {dbg_ra, dbg_rb}, {e.ra, e.rb});
            check(dbg_flags == e.fl, "R8", "flags across branch", dbg_flags, e.fl);
            if (e.cls == 2'd1)
              check(dbg_pc == e.pc, "R9", "jump target", dbg_pc, e.pc);
            else
              check(dbg_pc == e.pc, "R10", "conditional branch PC", dbg_pc, e.pc);
          end
          n_done++;
        end
      end
      have_prev  <= 1'b1;
      prev_phase <= dbg_phase;
      snap_ra    <= dbg_ra;
      snap_rb    <= dbg_rb;
      snap_pc    <= dbg_pc;
      snap_fl    <= dbg_flags;
    end
  end

  initial begin
    int cyc;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(dbg_ra == 8'h00, "R1", "RA in reset", dbg_ra, 0);
    check(dbg_rb == 8'h00, "R1", "RB in reset", dbg_rb, 0);
    check(dbg_pc == 8'h00, "R1", "PC in reset", dbg_pc, 0);
    check(dbg_flags == 4'h0, "R1", "flags in reset", dbg_flags, 0);
    check(dbg_phase == 1'b0, "R1", "phase in reset", dbg_phase, 0);
    drive_expected(N_STEPS);
    #2;
    rst_n  = 1'b1;
    mon_on = 1'b1;
    cyc = 0;
    while (n_done < N_STEPS && cyc < WD_MAX) begin
      @(negedge clk);
      cyc++;
    end
    #1;
    if (n_done < N_STEPS) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d instructions expected %0d", n_done, N_STEPS);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule